// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block is the interrupt front end for a bank of general-purpose input lines. Each line passes through a two-flop synchronizer and is then optionally inverted by a per-line polarity bit. The result is the line's data-in value, which software can read. Two cause paths follow. The level path is the data-in value itself, qualified by a level mask. The edge path is a sticky bit that is set on every 0-to-1 transition of the polarity-adjusted value and is qualified by an edge mask.

The combined cause of each line is also gated by its direction bit, so that only lines configured as inputs can interrupt. The causes are then OR-reduced in groups of eight lines. The result is one summary interrupt per group, sent to the main interrupt controller.

Software works through a small word-wide register port. Writes take effect on the clock edge. Reads are combinational on the address. A falling edge is caught by setting the line's polarity bit, and polarity changes never create an edge cause by themselves. Toggling polarity from software therefore catches both edges of a line.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset the polarity, level mask, edge mask and edge cause registers read zero, the direction register reads all ones (every line an input), and every group interrupt is low.
- R2: Register address 1 reads the data-in value. This is the synchronized pin XOR the polarity bit, and it follows a pin change two clock edges later. Polarity 1 inverts the pin.
- R3: A line whose data-in bit and level mask bit are both 1 raises its group interrupt. Nothing is latched, so the interrupt falls once the data-in bit returns to 0.
- R4: A 0-to-1 transition of a data-in bit sets that bit of the edge cause register (address 4). The bit stays set after the line returns to 0.
- R5: A set edge cause bit raises its group interrupt only while its edge mask bit (address 3) is 1. Unmasking an already set cause raises the interrupt.
- R6: A write to address 4 clears each edge cause bit written as 0 and leaves each bit written as 1 unchanged.
- R7: When a new edge on a line coincides with a clearing write to address 4, that line's cause bit ends up set.
- R8: With polarity 1 a falling pin edge sets the cause bit and a rising pin edge does not. A write to the polarity register (address 0) alone never sets a cause bit.
- R9: Lines 8g to 8g+7 drive only group interrupt bit g.
- R10: A line whose direction bit (address 5) is 0 contributes nothing to its group interrupt.
- R11: Addresses 0, 2, 3 and 5 read back the last value written. A write to address 1 has no effect, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | LINES | Asynchronous GPIO pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 polarity, 1 data-in, 2 level mask, 3 edge mask, 4 edge cause, 5 direction) |
| reg_wdata | input | LINES | Register write data |
| reg_rdata | output | LINES | Register read data for reg_addr |
| grp_irq | output | LINES/GROUP | One summary interrupt per group of GROUP lines |

## Verification
A mixed pin pattern of alternating nibbles is used to check that data-in matches the pins, which shows that no bit is lost or swapped, and then with half the polarity bits set, which shows that inversion is applied bit by bit. Single-line rise and fall steps under level masking and under edge masking are used to tell the transparent level path apart from the sticky edge path. The same single-line steps under falling polarity show that the edge detector follows the adjusted value and not the raw pin. A rising edge timed into the same cycle as a clearing write shows the set-over-clear priority. Lines placed in different bytes show that each one maps to its own group output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_POL    = 3'd0,
        RA_DIN    = 3'd1,
        RA_LVL    = 3'd2,
        RA_EMSK   = 3'd3,
        RA_ECAUSE = 3'd4,
        RA_DIR    = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_group_or.sv
module gpio_irq_group_or #(
    parameter int unsigned LINES = 32,
    parameter int unsigned GROUP = 8,
    localparam int unsigned NGRP = LINES / GROUP
) (
    input  logic [LINES-1:0] cause_i,
    output logic [NGRP-1:0]  grp_o
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_o[g] = |cause_i[g*GROUP +: GROUP];
    end

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned GROUP  = 8,
    parameter int unsigned STAGES = 2,
    localparam int unsigned NGRP  = LINES / GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic [NGRP-1:0]   grp_irq
);

    typedef struct packed {
        logic [LINES-1:0] pol;
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] emsk;
        logic [LINES-1:0] ecause;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    logic [LINES-1:0] sync_pin;
    logic [LINES-1:0] din;
    logic [LINES-1:0] edge_hit;
    logic [LINES-1:0] clr_keep;
    logic [LINES-1:0] cause_all;

    gpio_irq_sync #(.W(LINES), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (sync_pin)
    );

    always_comb begin
        st_d     = st_q;
        din      = sync_pin ^ st_q.pol;
        // both samples are adjusted by the present polarity, so a polarity
        // write alone leaves the comparison unchanged
        edge_hit = din & ~(st_q.prev ^ st_q.pol);
        st_d.prev = sync_pin;

        clr_keep = '1;
        if (reg_we) begin
            case (reg_addr)
                RA_POL:    st_d.pol  = reg_wdata;
                RA_LVL:    st_d.lvl  = reg_wdata;
                RA_EMSK:   st_d.emsk = reg_wdata;
                RA_ECAUSE: clr_keep  = reg_wdata;
                RA_DIR:    st_d.dir  = reg_wdata;
                default:   ;
            endcase
        end
        // a new edge wins over a clear in the same cycle
        st_d.ecause = (st_q.ecause & clr_keep) | edge_hit;

        cause_all = ((din & st_q.lvl) | (st_q.ecause & st_q.emsk)) & st_q.dir;

        case (reg_addr)
            RA_POL:    reg_rdata = st_q.pol;
            RA_DIN:    reg_rdata = din;
            RA_LVL:    reg_rdata = st_q.lvl;
            RA_EMSK:   reg_rdata = st_q.emsk;
            RA_ECAUSE: reg_rdata = st_q.ecause;
            RA_DIR:    reg_rdata = st_q.dir;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.dir    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    gpio_irq_group_or #(.LINES(LINES), .GROUP(GROUP)) u_grp (
        .cause_i(cause_all),
        .grp_o  (grp_irq)
    );

    // plain views for the bound checker
    logic [LINES-1:0] v_lvl, v_emsk, v_ecause, v_dir;
    assign v_lvl    = st_q.lvl;
    assign v_emsk   = st_q.emsk;
    assign v_ecause = st_q.ecause;
    assign v_dir    = st_q.dir;

endmodule

// File: rtl/gpio_irq_cause_chk.sv
module gpio_irq_cause_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES = 32,
    parameter int unsigned GROUP = 8,
    localparam int unsigned NGRP = LINES / GROUP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LINES-1:0]  reg_wdata,
    input logic [NGRP-1:0]   grp_irq,
    input logic [LINES-1:0]  din,
    input logic [LINES-1:0]  lvl,
    input logic [LINES-1:0]  emsk,
    input logic [LINES-1:0]  ecause,
    input logic [LINES-1:0]  dir,
    input logic [LINES-1:0]  edge_hit
);

    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == RA_ECAUSE);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ecause == '0 && grp_irq == '0)) else $error("reset idle"); // R1

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((ecause & $past(edge_hit)) == $past(edge_hit))) else $error("edge set"); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(ecause) & ~ecause) == '0)) else $error("edge sticky"); // R6

    AST_CLEAR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ecause & ~$past(reg_wdata) & ~$past(edge_hit)) == '0)) else $error("clear"); // R7

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0 && emsk == '0) |-> (grp_irq == '0)) else $error("mask quiet"); // R5

    AST_DIR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == '0) |-> (grp_irq == '0)) else $error("dir gate"); // R10

    for (genvar g = 0; g < NGRP; g++) begin : g_lvl
        AST_LEVEL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            (|(din[g*GROUP +: GROUP] & lvl[g*GROUP +: GROUP] & dir[g*GROUP +: GROUP]))
            |-> grp_irq[g]) else $error("level group"); // R3
    end

endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(.LINES(LINES), .GROUP(GROUP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .grp_irq  (grp_irq),
    .din      (din),
    .lvl      (v_lvl),
    .emsk     (v_emsk),
    .ecause   (v_ecause),
    .dir      (v_dir),
    .edge_hit (edge_hit)
);

// File: tb/gpio_irq_cause_tb.sv
`timescale 1ns/1ps
module gpio_irq_cause_tb;

    localparam int LINES = 32;
    localparam int NGRP  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] pin_in = '0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [LINES-1:0] reg_wdata = '0;
    logic [LINES-1:0] reg_rdata;
    logic [NGRP-1:0]  grp_irq;

    always #2.5 clk = ~clk;

    gpio_irq_cause u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .grp_irq(grp_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [LINES-1:0] p = '0;

    // monitor: compares queued expectations against the outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {28'd0, grp_irq} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(posedge clk); #1;
        pin_in = v; p = v;
        idle(4);
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_irq(input logic [3:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {28'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3); #1;
        rst_n = 1'b1;

        // R1 reset state
        chk_reg(3'd0, 32'h0, "R1 polarity");
        chk_reg(3'd2, 32'h0, "R1 level mask");
        chk_reg(3'd3, 32'h0, "R1 edge mask");
        chk_reg(3'd4, 32'h0, "R1 edge cause");
        chk_reg(3'd5, 32'hFFFF_FFFF, "R1 direction");
        chk_irq(4'h0, "R1 irq");

        // R11 register readback and ignored addresses
        wr(3'd2, 32'h1234_5678);
        chk_reg(3'd2, 32'h1234_5678, "R11 level readback");
        wr(3'd5, 32'h0F0F_F0F0);
        chk_reg(3'd5, 32'h0F0F_F0F0, "R11 dir readback");
        wr(3'd1, 32'hDEAD_BEEF);
        chk_reg(3'd1, 32'h0, "R11 din write ignored");
        chk_reg(3'd6, 32'h0, "R11 addr6 zero");
        chk_reg(3'd7, 32'h0, "R11 addr7 zero");
        wr(3'd2, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);

        // R2 data-in, R4 edge cause, R8 polarity write
        pins(32'hA5A5_0F0F);
        chk_reg(3'd1, 32'hA5A5_0F0F, "R2 din plain");
        chk_reg(3'd4, 32'hA5A5_0F0F, "R4 rising causes");
        wr(3'd0, 32'hFFFF_0000);
        idle(3);
        chk_reg(3'd1, 32'hA5A5_0F0F ^ 32'hFFFF_0000, "R2 din inverted");
        chk_reg(3'd4, 32'hA5A5_0F0F, "R8 polarity write no cause");
        wr(3'd0, 32'h0);
        idle(3);
        chk_reg(3'd4, 32'hA5A5_0F0F, "R8 polarity restore no cause");

        // R6 clear semantics
        wr(3'd4, 32'hFFFF_0000);
        chk_reg(3'd4, 32'hA5A5_0000, "R6 partial clear");
        wr(3'd4, 32'h0);
        chk_reg(3'd4, 32'h0, "R6 full clear");

        // R3 level path
        wr(3'd2, 32'h0000_0100);
        chk_irq(4'b0010, "R3 level high");
        pins(p & ~32'h0000_0100);
        chk_irq(4'b0000, "R3 level follows pin");
        pins(p | 32'h0000_0100);
        chk_irq(4'b0010, "R3 level again");
        chk_reg(3'd4, 32'h0000_0100, "R4 edge bit8 set");

        // R5 edge mask
        wr(3'd2, 32'h0);
        chk_irq(4'b0000, "R5 edge masked");
        wr(3'd3, 32'h0000_0100);
        chk_irq(4'b0010, "R5 edge unmasked");
        wr(3'd4, 32'h0);
        chk_irq(4'b0000, "R5 cleared");
        wr(3'd3, 32'h0);

        // R10 direction gating
        wr(3'd2, 32'h0100_0000);
        chk_irq(4'b1000, "R10 input line");
        wr(3'd5, 32'hFEFF_FFFF);
        chk_irq(4'b0000, "R10 output line gated");
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0);

        // R8 falling edge with polarity 1
        wr(3'd0, 32'h0000_0001);
        idle(3);
        chk_reg(3'd4, 32'h0, "R8 no cause on pol write");
        pins(p & ~32'h1);
        chk_reg(3'd4, 32'h1, "R8 falling edge caught");
        wr(3'd3, 32'h1);
        chk_irq(4'b0001, "R9 group0");
        wr(3'd4, 32'h0);
        pins(p | 32'h1);
        chk_reg(3'd4, 32'h0, "R8 rising ignored under pol1");
        wr(3'd0, 32'h0);
        idle(3);
        chk_reg(3'd4, 32'h0, "R8 pol back no cause");
        wr(3'd3, 32'h0);

        // R7 edge coinciding with clear
        pins(p | 32'h10);
        chk_reg(3'd4, 32'h10, "R7 prep bit4");
        @(posedge clk); #1;
        pin_in = p | 32'h20; p = p | 32'h20;
        @(posedge clk);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0;
        @(posedge clk); #1;
        reg_we = 1'b0;
        chk_reg(3'd4, 32'h20, "R7 edge beats clear");

        // R9 group mapping
        wr(3'd3, 32'hFFFF_FFFF);
        chk_irq(4'b0001, "R9 bit5 to group0");
        wr(3'd4, 32'h0);
        chk_irq(4'b0000, "R9 cleared");
        pins(p | 32'h0002_0000);
        chk_irq(4'b0100, "R9 bit17 to group2");

        idle(3);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule